// File: doc/BRIEF.md
# Dual Lookup-Table Slice with Selectable Storage Modes

This block holds two 16-bit storage cells, each addressed by its own 4-bit input. The same cell contents serve four purposes, chosen by a mode code. A cell can be a fixed logic function: its 16 bits are the truth table of any function of the four inputs. It can be a small RAM with an asynchronous read port and a write on the clock edge. It can be a 16-stage shift register with a tap chosen by the address. The two cells can also be joined into one memory that is 32 deep or 16 words by 2 bits.

Each combinational output feeds its own storage element. A per-output select sets that element to act as an edge-triggered flip-flop or as a latch that is open while the clock is high.

A truth table is loaded by writing the cells in a RAM mode. Switching to the logic mode then freezes the contents.

Top module: `dual_lut_slice`

## Requirements
- R1: While `rst_n` is low, every bit of both cells is 0 and both `comb_out` and `reg_out` are 0.
- R2: In mode code 1 (two independent 16x1 RAMs), with `we` high, cell k stores `din[k]` at address `addr_k` on the rising clock edge (k=0 uses `addr_a`, k=1 uses `addr_b`). With `we` low, no bit changes.
- R3: In mode codes 0, 1 and 2, `comb_out[k]` is bit `addr_k` of cell k, and it follows address changes without a clock edge.
- R4: In mode code 3 (32x1), the 5-bit address is {`sel_hi`, `addr_a`}. A write with `we` high stores `din[0]` into cell `sel_hi` at `addr_a`. `comb_out[0]` reads that same cell and address, and `comb_out[1]` reads cell 1 at `addr_a`.
- R5: In mode code 4 (16x2), both cells use `addr_a` and `addr_b` is ignored. A write with `we` high stores `din[1:0]` into the two cells, and `comb_out[1:0]` reads both cells.
- R6: In mode code 2 (shift), each rising edge with `shift_en` high moves cell k up one position and puts `din[k]` into bit 0. `addr_k` selects the tap that drives `comb_out[k]`. With `shift_en` low, the cell holds its contents.
- R7: In mode code 0 (logic), and in the unused codes 5 to 7, `we` and `shift_en` are ignored and the cell contents never change.
- R8: With `store_latch[k]` at 0, `reg_out[k]` takes the value of `comb_out[k]` at each rising clock edge and holds it until the next rising edge.
- R9: With `store_latch[k]` at 1, `reg_out[k]` follows `comb_out[k]` while `clk` is high and holds its value while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge writes and shifts; also the latch gate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Mode code: 0 logic, 1 dual 16x1 RAM, 2 shift, 3 32x1 RAM, 4 16x2 RAM |
| addr_a | input | 4 | Address or logic inputs of cell 0 (shared address in modes 3 and 4) |
| addr_b | input | 4 | Address or logic inputs of cell 1 |
| sel_hi | input | 1 | Fifth address bit in 32x1 mode |
| we | input | 1 | Write enable for the RAM modes |
| din | input | 2 | Write or shift data, bit k for cell k |
| shift_en | input | 1 | Shift enable for shift mode |
| store_latch | input | 2 | Per output: 1 latch, 0 flip-flop |
| comb_out | output | 2 | Combinational read of each cell |
| reg_out | output | 2 | Output of each storage element |

## Verification
A wrong bit in a cell appears on `comb_out` as soon as that address is presented, with no clock in between. For this reason, every sweep reads all addresses of both cells right after each write or shift phase. A write or shift that happens when it should not stays hidden until that location is read. The sweeps after the ignored-stimulus phases therefore read every location. A faulty storage element shows up within one clock phase: a flip-flop that is open too early, or a latch that does not hold during the low phase, is caught on the same cycle it is sampled.

// File: rtl/lut_slice_pkg.sv
`timescale 1ns/1ps
package lut_slice_pkg;

  typedef enum logic [2:0] {
    MD_LOGIC   = 3'd0,
    MD_RAM16   = 3'd1,
    MD_SHIFT   = 3'd2,
    MD_RAM32   = 3'd3,
    MD_RAM16X2 = 3'd4
  } slice_mode_e;

  // both cells driven from addr_a
  function automatic logic addr_shared(input logic [2:0] md);
    return (md == MD_RAM32) || (md == MD_RAM16X2);
  endfunction

  // write strobe for cell idx
  function automatic logic elem_write(input logic [2:0] md, input logic wen,
                                      input logic hi, input logic idx);
    logic r;
    case (md)
      MD_RAM16, MD_RAM16X2: r = wen;
      MD_RAM32:             r = wen && (hi == idx);
      default:              r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic elem_shift(input logic [2:0] md, input logic sen);
    return (md == MD_SHIFT) && sen;
  endfunction

endpackage

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell #(
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    sh_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_bit,
  input  logic                    sh_bit,
  output logic                    rd_bit,
  output logic [(1<<ADDR_W)-1:0]  bits
);
  localparam int DEPTH = 1 << ADDR_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bits <= '0;
    else if (sh_en)
      bits <= {bits[DEPTH-2:0], sh_bit};
    else if (wr_en)
      bits[addr] <= wr_bit;
  end

  assign rd_bit = bits[addr];
endmodule

// File: rtl/store_elem.sv
`timescale 1ns/1ps
module store_elem (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_sel,
  input  logic d,
  output logic q
);
  logic ff_q;
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= d;
  end

  always_latch begin
    if (!rst_n)   lat_q = 1'b0;
    else if (clk) lat_q = d;
  end

  assign q = latch_sel ? lat_q : ff_q;
endmodule

// File: rtl/dual_lut_slice.sv
`timescale 1ns/1ps
module dual_lut_slice
  import lut_slice_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              sel_hi,
  input  logic              we,
  input  logic [1:0]        din,
  input  logic              shift_en,
  input  logic [1:0]        store_latch,
  output logic [1:0]        comb_out,
  output logic [1:0]        reg_out
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int N_ELEM = 2;

  logic                               shared_addr;
  logic                               deep_mode;
  logic [N_ELEM-1:0]                  wr_en;
  logic [N_ELEM-1:0]                  sh_en;
  logic [N_ELEM-1:0]                  rd_bit;
  logic [N_ELEM-1:0][ADDR_W-1:0]      el_addr;
  logic [N_ELEM-1:0][DEPTH-1:0]       cell_bits;

  assign shared_addr = addr_shared(mode);
  assign deep_mode   = (mode == MD_RAM32);

  for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
    assign el_addr[k] = shared_addr ? addr_a : ((k == 0) ? addr_a : addr_b);
    assign wr_en[k]   = elem_write(mode, we, sel_hi, 1'(k));
    assign sh_en[k]   = elem_shift(mode, shift_en);

    lut_cell #(.ADDR_W(ADDR_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en[k]),
      .sh_en  (sh_en[k]),
      .addr   (el_addr[k]),
      .wr_bit (deep_mode ? din[0] : din[k]),
      .sh_bit (din[k]),
      .rd_bit (rd_bit[k]),
      .bits   (cell_bits[k])
    );

    store_elem u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_sel (store_latch[k]),
      .d         (comb_out[k]),
      .q         (reg_out[k])
    );
  end

  always_comb begin
    comb_out[0] = deep_mode ? rd_bit[sel_hi] : rd_bit[0];
    comb_out[1] = rd_bit[1];
  end
endmodule

// File: rtl/slice_checker.sv
`timescale 1ns/1ps
module slice_checker
  import lut_slice_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic [2:0]                           mode,
  input logic [ADDR_W-1:0]                    addr_a,
  input logic [ADDR_W-1:0]                    addr_b,
  input logic                                 sel_hi,
  input logic                                 we,
  input logic [1:0]                           din,
  input logic                                 shift_en,
  input logic [1:0]                           store_latch,
  input logic [1:0]                           comb_out,
  input logic [1:0]                           reg_out,
  input logic [1:0][(1<<ADDR_W)-1:0]          cell_bits
);
  localparam int DEPTH = 1 << ADDR_W;

  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (cell_bits == '0);
  end

  assert_ram_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RAM16 && we) |=> cell_bits[0][$past(addr_a)] == $past(din[0]));

  assert_deep_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RAM32) |-> comb_out[0] == cell_bits[sel_hi][addr_a]);

  assert_wide_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RAM16X2 && we) |=> cell_bits[1][$past(addr_a)] == $past(din[1]));

  assert_shift_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SHIFT && shift_en) |=>
      cell_bits[0] == {$past(cell_bits[0][DEPTH-2:0]), $past(din[0])});

  assert_logic_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_LOGIC) |=> $stable(cell_bits));

  assert_ff_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!store_latch[0] && !$past(store_latch[0])) |-> reg_out[0] == $past(comb_out[0]));
endmodule

bind dual_lut_slice slice_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dual_lut_slice.sv
`timescale 1ns/1ps
module sim_dual_lut_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [3:0] addr_a = '0, addr_b = '0;
  logic       sel_hi = 1'b0, we = 1'b0, shift_en = 1'b0;
  logic [1:0] din = '0, store_latch = '0;
  logic [1:0] comb_out, reg_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] mA = '0, mB = '0;

  always #2.5 clk = ~clk;

  dual_lut_slice u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .addr_a(addr_a),
    .addr_b(addr_b), .sel_hi(sel_hi), .we(we), .din(din), .shift_en(shift_en),
    .store_latch(store_latch), .comb_out(comb_out), .reg_out(reg_out));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // leaves time at rising edge + 1 ns, clock still high
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(15 - a); #0.2;
      chk(req, comb_out, {mB[15-a], mA[a]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    repeat (3) cyc();
    chk("R1 reset comb", comb_out, 2'b00);
    chk("R1 reset reg", reg_out, 2'b00);
    rst_n = 1'b1;
    cyc();

    // R2 fill both cells
    mode = 3'd1; we = 1'b1;
    for (int a = 0; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(a);
      din = {logic'(a % 3 == 0), ^(4'(a))};
      cyc();
      mA[a] = ^(4'(a)); mB[a] = (a % 3 == 0);
    end
    we = 1'b0;
    sweep("R3 async read after R2 fill");
    // R2 with we low: no change
    for (int a = 0; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(a); din = ~{mB[a], mA[a]}; cyc();
    end
    sweep("R2 we low keeps cells");

    // R7 logic mode and unused code ignore write and shift
    mode = 3'd0; we = 1'b1; shift_en = 1'b1;
    for (int a = 0; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(a); din = ~{mB[a], mA[a]}; cyc();
    end
    we = 1'b0; shift_en = 1'b0;
    sweep("R7 logic mode frozen");
    mode = 3'd6; we = 1'b1; shift_en = 1'b1;
    for (int a = 0; a < 6; a++) begin
      addr_a = 4'(a); addr_b = 4'(a); din = ~{mB[a], mA[a]}; cyc();
    end
    we = 1'b0; shift_en = 1'b0;
    sweep("R7 unused code frozen");

    // R8 flip-flop outputs
    mode = 3'd0; store_latch = 2'b00;
    addr_a = 4'd0; addr_b = 4'd0; cyc();
    prev = {mB[0], mA[0]};
    for (int a = 1; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(a); #0.2;
      chk("R8 ff holds before edge", reg_out, prev);
      cyc();
      chk("R8 ff captures at edge", reg_out, {mB[a], mA[a]});
      prev = {mB[a], mA[a]};
    end

    // R9 latch outputs
    store_latch = 2'b11;
    for (int p = 0; p < 8; p++) begin
      cyc();
      addr_a = 4'(2*p); addr_b = 4'(2*p); #0.2;
      chk("R9 latch open high", reg_out, {mB[2*p], mA[2*p]});
      @(negedge clk); #0.5;
      addr_a = 4'(2*p+1); addr_b = 4'(2*p+1); #0.2;
      chk("R9 latch holds low", reg_out, {mB[2*p], mA[2*p]});
      @(posedge clk); #0.3;
      chk("R9 latch reopens", reg_out, {mB[2*p+1], mA[2*p+1]});
    end
    store_latch = 2'b00;

    // R6 shift register
    mode = 3'd2; shift_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      din = {logic'(i % 5 == 1), logic'(((i * 3) >> 1) & 1)};
      cyc();
      mA = {mA[14:0], din[0]}; mB = {mB[14:0], din[1]};
      addr_a = 4'(i % 16); addr_b = 4'd0; #0.2;
      chk("R6 shift tap", comb_out, {mB[0], mA[i % 16]});
    end
    shift_en = 1'b0;
    for (int i = 0; i < 4; i++) begin din = ~din; cyc(); end
    sweep("R6 shift disabled holds");

    // R4 32x1 memory
    mode = 3'd3; we = 1'b1;
    for (int x = 0; x < 32; x++) begin
      sel_hi = logic'(x >> 4); addr_a = 4'(x); addr_b = 4'(~x);
      din = {1'b1, logic'(((x * 11) % 7) < 3)};
      cyc();
      if (x >= 16) mB[x-16] = din[0]; else mA[x] = din[0];
    end
    we = 1'b0;
    for (int x = 0; x < 32; x++) begin
      sel_hi = logic'(x >> 4); addr_a = 4'(x); addr_b = 4'(x + 5); #0.2;
      chk("R4 deep read", comb_out,
          {mB[x % 16], (x >= 16) ? mB[x % 16] : mA[x % 16]});
    end
    sel_hi = 1'b0;

    // R5 16x2 memory
    mode = 3'd4; we = 1'b1;
    for (int a = 0; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(a + 7);
      din = {logic'(a > 2 && a < 9), logic'(a[0] ^ a[3])};
      cyc();
      mA[a] = din[0]; mB[a] = din[1];
    end
    we = 1'b0;
    for (int a = 0; a < 16; a++) begin
      addr_a = 4'(a); addr_b = 4'(15 - a); #0.2;
      chk("R5 wide read", comb_out, {mB[a], mA[a]});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule